// File: doc/BRIEF.md
# Bus Initiator with Claim Timeout and Master Abort

This block is the requesting side of a shared bus whose address and data travel on the same wires. A local requester presents an address, a command code and a start strobe. The block starts a transaction only when the arbiter has granted it the bus (active-low grant) and the bus is idle, meaning both the frame and initiator-ready lines are sampled high. The transaction begins with a single address cycle. In that cycle the block drives the address and the command, each with its own output enable, and pulls the active-low frame strobe low.

After the address cycle the block stops driving the address and command and waits for a target to claim the transaction with the active-low device-select line. A claim seen on any clock from the second to the sixth, counting the address cycle as the first, sends the block to a one-clock handoff state for the data phase. If no claim arrives by the end of the sixth clock, the block ends the transaction itself with a master abort: it drives frame high, sets a sticky abort flag and, for a read, returns an all-ones data word. The transaction therefore finishes after a fixed number of cycles even when nothing responds.

Top module: `mux_bus_initiator`

## Requirements
- R1: A transaction starts only if, at a rising edge in the idle state, reqValid=1, gntN=0, frameInN=1 and irdyInN=1. The next clock is the address cycle. If any of these conditions is missing, no bus output is enabled.
- R2: The address cycle lasts exactly one clock. In it frameN=0, frameOe=1, adOe=1, cbeOe=1, adOut equals the captured address and cbeOut equals the captured command.
- R3: From the second clock until the final clock, adOe=0, cbeOe=0, frameOe=1 and frameN=0.
- R4: If devselN=0 is sampled on clock k, where k is from 2 to 6, then clock k+1 is the final clock, with handoff=1, done=1, frameN=0 and no abort. devselN=0 during the address cycle is ignored.
- R5: If devselN stays high through clock 6, clock 7 is the final clock, with frameN=1, frameOe=1, done=1 and handoff=0, and abortFlag is set.
- R6: In a master abort of a read (cmd bit 0 = 0), rdData becomes 32'hFFFFFFFF from clock 7 on. A write abort (cmd bit 0 = 1) leaves rdData unchanged.
- R7: busy is 1 from the address cycle through the final clock and 0 on the clock after it. reqValid while busy is ignored.
- R8: abortFlag stays set until abortClr=1 is sampled. If an abort is being recorded on the same edge, the set wins over the clear.
- R9: After reset, frameN=1, frameOe=0, adOe=0, cbeOe=0, busy=0, done=0, handoff=0, abortFlag=0 and rdData=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start request from the local requester |
| reqAddr | input | 32 | Target address for the request |
| reqCmd | input | 4 | Command code; bit 0 = 0 means read |
| busy | output | 1 | A transaction is in progress |
| gntN | input | 1 | Bus grant, active low |
| frameInN | input | 1 | Sampled frame line, high when idle |
| irdyInN | input | 1 | Sampled initiator-ready line, high when idle |
| devselN | input | 1 | Target claim, active low |
| adOut | output | 32 | Address driven onto the shared bus |
| adOe | output | 1 | Output enable for adOut |
| cbeOut | output | 4 | Command driven onto the command/byte-enable lines |
| cbeOe | output | 1 | Output enable for cbeOut |
| frameN | output | 1 | Frame strobe, active low |
| frameOe | output | 1 | Output enable for frameN |
| done | output | 1 | One-clock pulse on the final clock of a transaction |
| handoff | output | 1 | Claimed; handing over to the data phase |
| rdData | output | 32 | Data returned to the requester |
| abortFlag | output | 1 | Sticky master-abort status |
| abortClr | input | 1 | Write-one-to-clear for abortFlag |

## Verification
The bench drives inputs and samples outputs on falling edges. A request seen at one rising edge produces the address cycle in the next falling-edge sample. After that, each further falling edge is the next clock of the transaction. A claim driven during clock k is due as handoff in the sample of clock k+1. A missing claim is due as the abort in the sample of clock 7, and busy is due low one sample after done. Each scenario task counts clocks from the address cycle and compares the outputs at exactly those samples. Where a request must be ignored, the task instead watches that the output enables stay low for several clocks.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_HANDOFF,
    ST_ABORT
  } mbi_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic setAbort;
  } mbi_strobe_t;
endpackage

// File: rtl/mbi_ctrl.sv
module mbi_ctrl
  import mbi_pkg::*;
#(
  parameter int CLAIM_LIMIT = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        gntN,
  input  logic        frameInN,
  input  logic        irdyInN,
  input  logic        devselN,
  output mbi_strobe_t stb,
  output logic        frameN,
  output logic        frameOe,
  output logic        busy,
  output logic        done,
  output logic        handoff
);
  localparam int CNT_W = $clog2(CLAIM_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CLK = CNT_W'(CLAIM_LIMIT);
  localparam logic [CNT_W-1:0] FIRST_WAIT = CNT_W'(2);

  mbi_state_e state, stateNext;
  logic [CNT_W-1:0] clkCnt;
  logic startOk, timeout;

  assign startOk = reqValid && !gntN && frameInN && irdyInN;
  assign timeout = devselN && (clkCnt == LAST_CLK);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (startOk) stateNext = ST_ADDR;
      ST_ADDR:    stateNext = ST_WAIT;
      ST_WAIT: begin
        if (!devselN)     stateNext = ST_HANDOFF;
        else if (timeout) stateNext = ST_ABORT;
      end
      ST_HANDOFF: stateNext = ST_IDLE;
      ST_ABORT:   stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      clkCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_ADDR)      clkCnt <= FIRST_WAIT;
      else if (state == ST_WAIT) clkCnt <= clkCnt + 1'b1;
      else                       clkCnt <= '0;
    end
  end

  always_comb begin
    stb.loadReq   = (state == ST_IDLE) && startOk;
    stb.driveAddr = (state == ST_ADDR);
    stb.setAbort  = (state == ST_WAIT) && timeout;
  end

  assign busy    = (state != ST_IDLE);
  assign frameOe = busy;
  assign frameN  = !(state == ST_ADDR || state == ST_WAIT || state == ST_HANDOFF);
  assign done    = (state == ST_HANDOFF) || (state == ST_ABORT);
  assign handoff = (state == ST_HANDOFF);
endmodule

// File: rtl/mbi_datapath.sv
module mbi_datapath
  import mbi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbi_strobe_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CMD_W-1:0]  reqCmd,
  input  logic              abortClr,
  output logic [ADDR_W-1:0] adOut,
  output logic [CMD_W-1:0]  cbeOut,
  output logic              adOe,
  output logic              cbeOe,
  output logic [ADDR_W-1:0] rdData,
  output logic              abortFlag
);
  logic [ADDR_W-1:0] addrReg;
  logic [CMD_W-1:0]  cmdReg;
  logic              isRead;

  assign isRead = !cmdReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      cmdReg    <= '0;
      rdData    <= '0;
      abortFlag <= 1'b0;
    end else begin
      if (stb.loadReq) begin
        addrReg <= reqAddr;
        cmdReg  <= reqCmd;
      end
      if (stb.setAbort && isRead) rdData <= '1;
      if (stb.setAbort)           abortFlag <= 1'b1;
      else if (abortClr)          abortFlag <= 1'b0;
    end
  end

  assign adOe   = stb.driveAddr;
  assign cbeOe  = stb.driveAddr;
  assign adOut  = stb.driveAddr ? addrReg : '0;
  assign cbeOut = stb.driveAddr ? cmdReg : '0;
endmodule

// File: rtl/mux_bus_initiator.sv
module mux_bus_initiator
  import mbi_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CMD_W       = 4,
  parameter int CLAIM_LIMIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CMD_W-1:0]  reqCmd,
  output logic              busy,
  input  logic              gntN,
  input  logic              frameInN,
  input  logic              irdyInN,
  input  logic              devselN,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic [CMD_W-1:0]  cbeOut,
  output logic              cbeOe,
  output logic              frameN,
  output logic              frameOe,
  output logic              done,
  output logic              handoff,
  output logic [ADDR_W-1:0] rdData,
  output logic              abortFlag,
  input  logic              abortClr
);
  mbi_strobe_t stb;

  mbi_ctrl #(.CLAIM_LIMIT(CLAIM_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .gntN(gntN),
    .frameInN(frameInN), .irdyInN(irdyInN), .devselN(devselN),
    .stb(stb), .frameN(frameN), .frameOe(frameOe), .busy(busy),
    .done(done), .handoff(handoff)
  );

  mbi_datapath #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .abortClr(abortClr), .adOut(adOut), .cbeOut(cbeOut), .adOe(adOe),
    .cbeOe(cbeOe), .rdData(rdData), .abortFlag(abortFlag)
  );
endmodule

// File: rtl/mbi_checker.sv
module mbi_checker #(
  parameter int CLAIM_LIMIT = 6
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic gntN,
  input logic frameInN,
  input logic irdyInN,
  input logic abortClr,
  input logic adOe,
  input logic cbeOe,
  input logic frameN,
  input logic frameOe,
  input logic busy,
  input logic done,
  input logic handoff,
  input logic abortFlag
);
  localparam int RUN_W = $clog2(CLAIM_LIMIT + 3);
  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowRun <= '0;
    else if (frameOe && !frameN) lowRun <= lowRun + 1'b1;
    else                       lowRun <= '0;
  end

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> adOe && $past(reqValid && !gntN && frameInN && irdyInN));

  // R2
  addr_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |=> !adOe && !cbeOe);

  // R2
  addr_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> cbeOe && frameOe && !frameN);

  // R4
  handoff_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    handoff |-> done && !frameN && busy);

  // R5
  abort_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortFlag) |-> done && frameN && frameOe && !handoff);

  // R5
  claim_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= RUN_W'(CLAIM_LIMIT + 1));

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortClr && !busy |=> !abortFlag);
endmodule

bind mux_bus_initiator mbi_checker #(.CLAIM_LIMIT(CLAIM_LIMIT)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .gntN(gntN),
  .frameInN(frameInN), .irdyInN(irdyInN), .abortClr(abortClr),
  .adOe(adOe), .cbeOe(cbeOe), .frameN(frameN), .frameOe(frameOe),
  .busy(busy), .done(done), .handoff(handoff), .abortFlag(abortFlag)
);

// File: tb/mux_bus_initiator_bench.sv
`timescale 1ns/1ps
module mux_bus_initiator_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0] reqCmd = '0;
  logic gntN = 1'b1, frameInN = 1'b1, irdyInN = 1'b1, devselN = 1'b1;
  logic abortClr = 1'b0;
  logic busy, adOe, cbeOe, frameN, frameOe, done, handoff, abortFlag;
  logic [31:0] adOut, rdData;
  logic [3:0] cbeOut;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  mux_bus_initiator u_mux_bus_initiator (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .busy(busy), .gntN(gntN), .frameInN(frameInN),
    .irdyInN(irdyInN), .devselN(devselN), .adOut(adOut), .adOe(adOe),
    .cbeOut(cbeOut), .cbeOe(cbeOe), .frameN(frameN), .frameOe(frameOe),
    .done(done), .handoff(handoff), .rdData(rdData), .abortFlag(abortFlag),
    .abortClr(abortClr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Request, then walk clock by clock; claimAt = clock of devsel (0 = none).
  // pokeBusy drives a second request during clock 3 that must be ignored.
  task automatic runTxn(input logic [31:0] a, input logic [3:0] c, input int claimAt,
                        input logic [31:0] expRd, input bit pokeBusy);
    bit claimed = 0;
    @(negedge clk);
    reqValid = 1'b1; gntN = 1'b0; reqAddr = a; reqCmd = c;
    @(negedge clk);  // clock 1: address cycle
    reqValid = 1'b0; gntN = 1'b1; reqAddr = ~a;
    check("R2 adOe", {31'd0, adOe}, 32'd1);
    check("R2 cbeOe", {31'd0, cbeOe}, 32'd1);
    check("R2 frameN", {31'd0, frameN}, 32'd0);
    check("R2 adOut", adOut, a);
    check("R2 cbeOut", {28'd0, cbeOut}, {28'd0, c});
    check("R7 busy addr", {31'd0, busy}, 32'd1);
    if (claimAt == 1) devselN = 1'b0;  // R4: ignored in address cycle
    for (int i = 2; i <= 6 && !claimed; i++) begin
      @(negedge clk);
      devselN = 1'b1;
      reqValid = 1'b0; gntN = 1'b1;
      check("R3 adOe off", {31'd0, adOe || cbeOe}, 32'd0);
      check("R3 frame held", {30'd0, frameN, frameOe}, 32'd1);
      check("R4 no early handoff", {31'd0, handoff}, 32'd0);
      if (pokeBusy && i == 3) begin reqValid = 1'b1; gntN = 1'b0; reqAddr = 32'h0BAD_0BAD; end
      if (i == claimAt) begin
        devselN = 1'b0;
        claimed = 1;
      end
    end
    @(negedge clk);  // final clock
    devselN = 1'b1; reqValid = 1'b0; gntN = 1'b1;
    check("R7 busy final", {31'd0, busy}, 32'd1);
    check("R4/R5 done", {31'd0, done}, 32'd1);
    if (claimed) begin
      check("R4 handoff", {31'd0, handoff}, 32'd1);
      check("R4 frameN low", {31'd0, frameN}, 32'd0);
    end else begin
      check("R5 no handoff", {31'd0, handoff}, 32'd0);
      check("R5 frame high", {30'd0, frameN, frameOe}, 32'd3);
      check("R5 abortFlag", {31'd0, abortFlag}, 32'd1);
    end
    check("R6 rdData", rdData, expRd);
    @(negedge clk);
    check("R7 idle after", {31'd0, busy}, 32'd0);
    check("R7 done pulse", {31'd0, done}, 32'd0);
    if (pokeBusy) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        check("R7 ignored request", {30'd0, frameOe, adOe}, 32'd0);
      end
    end
  endtask

  task automatic noStart(input logic g, input logic f, input logic ir, input string req);
    @(negedge clk);
    reqValid = 1'b1; gntN = g; frameInN = f; irdyInN = ir;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(req, {29'd0, busy, adOe, frameOe}, 32'd0);
    end
    reqValid = 1'b0; gntN = 1'b1; frameInN = 1'b1; irdyInN = 1'b1;
  endtask

  task automatic clearAbort();
    @(negedge clk);
    abortClr = 1'b1;
    @(negedge clk);
    abortClr = 1'b0;
    check("R8 cleared", {31'd0, abortFlag}, 32'd0);
  endtask

  task automatic resetCheck();
    @(negedge clk);
    check("R9 frameN", {31'd0, frameN}, 32'd1);
    check("R9 enables", {29'd0, frameOe, adOe, cbeOe}, 32'd0);
    check("R9 status", {28'd0, busy, done, handoff, abortFlag}, 32'd0);
    check("R9 rdData", rdData, 32'd0);
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    resetCheck();
    runTxn(32'h1234_5678, 4'h6, 2, 32'd0, 0);          // R4 claim at clock 2
    runTxn(32'hCAFE_0004, 4'h7, 6, 32'd0, 0);          // R4 claim at clock 6
    check("R8 no abort on claim", {31'd0, abortFlag}, 32'd0);
    runTxn(32'h0000_0CF8, 4'h3, 1, 32'd0, 0);          // R4 ignored, R6 write abort
    // R8 sticky across idle clocks
    repeat (2) @(negedge clk);
    check("R8 sticky", {31'd0, abortFlag}, 32'd1);
    clearAbort();
    runTxn(32'hFEED_BEEF, 4'h2, 0, 32'hFFFF_FFFF, 0);  // R5 R6 read abort
    clearAbort();
    noStart(1'b1, 1'b1, 1'b1, "R1 no grant");
    noStart(1'b0, 1'b0, 1'b1, "R1 frame busy");
    noStart(1'b0, 1'b1, 1'b0, "R1 irdy busy");
    runTxn(32'hA5A5_0000, 4'h6, 4, 32'hFFFF_FFFF, 1);  // R7 request while busy
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule